// File: doc/BRIEF.md
# DRAM Frequency-Change Sequencer

This block walks a DRAM controller from one frequency state to another without losing data. A single start pulse carries the index of the target state. The sequencer then works through a fixed order of steps. It closes the traffic port, drains the host path, and puts the memory into software self-refresh. While in self-refresh it publishes the new state, refreshes the refresh settings, and runs the PHY re-initialisation around the clock switch. It then waits a guard interval, leaves self-refresh, rewrites every mode register on every rank, and reopens traffic. Each step advances only when its status handshake confirms it.

The states, in order, are IDLE, SWD_CLR, QUIESCE, DRAIN, SR_ENTER, RFSH_UPD, PHY_LOW, PHY_HIGH, CLK_SW, PHY_DROP, GUARD, SR_EXIT, MR_PROG, RESTORE, SW_DONE, FINISH.

The transitions are as follows:
- IDLE leaves on start.
- SWD_CLR, RFSH_UPD, PHY_LOW, RESTORE and FINISH each last one cycle.
- QUIESCE leaves when both port-busy flags are low.
- DRAIN leaves when both queue-empty flags are high.
- SR_ENTER leaves when the operating mode equals 0x23.
- PHY_HIGH leaves when init-complete is low.
- CLK_SW leaves on the clock-switch acknowledge.
- PHY_DROP leaves when init-complete is high.
- GUARD leaves when the guard counter expires.
- SR_EXIT leaves when the operating mode differs from 0x23.
- MR_PROG leaves when the mode-register writer reports done.
- SW_DONE leaves on the software-done acknowledge.
- FINISH returns to IDLE.

Top module: `freq_change_seq`

## Requirements
- R1: After reset the outputs are as follows: busy low, done low, sw_done high, port enable high, host disable low, self-refresh request low, PHY init start low, clock-switch request low, MR request low, state index 0, refresh level 0.
- R2: On start, sw_done drops for one cycle while the port is still enabled. The port enable then drops. Host disable rises only in the cycle after both port-busy flags are seen low.
- R3: The self-refresh request rises only in the cycle after both queue-empty flags are seen high. The sequence does not go on until the 6-bit operating mode equals exactly 0x23; any other value, such as 0x03, keeps it waiting.
- R4: The state index output takes the latched target, and the refresh level inverts exactly once per sequence. Neither changes before the operating mode reads 0x23.
- R5: PHY init start is low for one cycle and then goes high. The clock-switch request rises only after init-complete has been seen low, and it is held until its acknowledge.
- R6: One cycle after the clock-switch acknowledge, both init start and the clock-switch request fall. Self-refresh stays requested until init-complete is high again.
- R7: Self-refresh is released exactly CLK_MHZ*GUARD_US+1 cycles after init-complete is first seen high. With the defaults this is 3501 cycles.
- R8: No mode-register request is raised while self-refresh is requested or while the operating mode still reads 0x23.
- R9: Mode registers are written for rank 0 up to NUM_RANKS-1. Within each rank the addresses run 0 to 6. The table slot equals the address, except that address 6 uses slot 7. Each request holds its address and rank steady until it is acknowledged.
- R10: After the last mode-register write, host disable clears and the port is re-enabled while sw_done is still low. Then sw_done is set. The done output pulses for one cycle only after the sw_done acknowledge. Busy is high from start through that pulse.
- R11: A start pulse while busy is ignored. The running sequence keeps its first target, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| target_i | input | PSW | Target frequency-state index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| port_busy_rd_i | input | 1 | Read port busy |
| port_busy_wr_i | input | 1 | Write port busy |
| wrq_empty_i | input | 1 | Write queue empty |
| rdq_empty_i | input | 1 | Read queue empty |
| op_mode_i | input | 6 | Controller operating-mode status |
| phy_init_cmpl_i | input | 1 | PHY init complete |
| clk_sw_ack_i | input | 1 | Clock-switch acknowledge |
| sw_done_ack_i | input | 1 | Software-done acknowledge |
| mr_ack_i | input | 1 | Mode-register write acknowledge |
| port_en_o | output | 1 | Traffic port enable |
| hif_dis_o | output | 1 | Host command interface disable |
| selfref_o | output | 1 | Software self-refresh request |
| pstate_o | output | PSW | Active frequency-state index |
| rfsh_lvl_o | output | 1 | Refresh-update level |
| phy_init_start_o | output | 1 | PHY init start |
| phy_freq_o | output | PSW | Frequency index presented to the PHY |
| clk_sw_req_o | output | 1 | Clock-switch request |
| sw_done_o | output | 1 | Software-done |
| mr_req_o | output | 1 | Mode-register write request |
| mr_addr_o | output | 3 | Mode-register address |
| mr_sel_o | output | 3 | Table slot of the value to write |
| mr_rank_o | output | RW | Rank being written |

## Verification
The bench holds every status flag in a misleading state before it releases it:
- It lowers one port-busy flag without the other, and raises one queue-empty flag without the other. A sequencer that tests only one flag would close the host path or enter self-refresh too early.
- It drives the operating mode to 0x03, whose low two bits already read as self-refresh. A design that compares only those bits would publish the new state too soon.
- It counts the guard interval to the exact cycle, which catches a counter that is one cycle off or loaded with the wrong value.
- It pulses start again in the middle of a sequence, which exposes a re-latched target.
- It checks the MR6 slot remap on every rank.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWD_CLR,
        ST_QUIESCE,
        ST_DRAIN,
        ST_SR_ENTER,
        ST_RFSH_UPD,
        ST_PHY_LOW,
        ST_PHY_HIGH,
        ST_CLK_SW,
        ST_PHY_DROP,
        ST_GUARD,
        ST_SR_EXIT,
        ST_MR_PROG,
        ST_RESTORE,
        ST_SW_DONE,
        ST_FINISH
    } fsc_state_e;

    // operating-mode code meaning "self-refresh entered by software"
    localparam logic [5:0] OPMODE_SR_SW = 6'h23;

    // mode registers rewritten per rank, and the slot used by the last one
    localparam int unsigned MR_COUNT     = 7;
    localparam logic [2:0]  MR_LAST_SLOT = 3'd7;

endpackage

// File: rtl/fsc_guard_timer.sv
module fsc_guard_timer #(
    parameter int unsigned CYCLES = 3500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

    // R7: the count never runs past its last value while armed
    p_guard_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && (cnt_q == LAST) |=> !run_i || (cnt_q == LAST));

endmodule

// File: rtl/fsc_mr_issuer.sv
module fsc_mr_issuer import fsc_pkg::*; #(
    parameter int unsigned NUM_RANKS = 2,
    localparam int unsigned RW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic [2:0]    addr_o,
    output logic [2:0]    sel_o,
    output logic [RW-1:0] rank_o,
    output logic          done_o
);
    localparam logic [2:0]    MR_LAST   = 3'(MR_COUNT - 1);
    localparam logic [RW-1:0] RANK_LAST = RW'(NUM_RANKS - 1);

    logic [2:0]    mr_q;
    logic [RW-1:0] rank_q;
    logic          fin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_q   <= '0;
            rank_q <= '0;
            fin_q  <= 1'b0;
        end else if (!go_i) begin
            mr_q   <= '0;
            rank_q <= '0;
            fin_q  <= 1'b0;
        end else if (!fin_q && ack_i) begin
            if (mr_q == MR_LAST) begin
                mr_q <= '0;
                if (rank_q == RANK_LAST) begin
                    fin_q <= 1'b1;
                end else begin
                    rank_q <= rank_q + 1'b1;
                end
            end else begin
                mr_q <= mr_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_o  = go_i && !fin_q;
        addr_o = mr_q;
        sel_o  = (mr_q == MR_LAST) ? MR_LAST_SLOT : mr_q;
        rank_o = rank_q;
        done_o = fin_q;
    end

    // R9: an unacknowledged request keeps its address and rank
    p_mr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(rank_o));

endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl import fsc_pkg::*; #(
    parameter int unsigned PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [PSW-1:0] target_i,
    input  logic           port_busy_rd_i,
    input  logic           port_busy_wr_i,
    input  logic           wrq_empty_i,
    input  logic           rdq_empty_i,
    input  logic [5:0]     op_mode_i,
    input  logic           phy_init_cmpl_i,
    input  logic           clk_sw_ack_i,
    input  logic           sw_done_ack_i,
    input  logic           guard_done_i,
    input  logic           mr_done_i,
    output logic           guard_run_o,
    output logic           mr_go_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           port_en_o,
    output logic           hif_dis_o,
    output logic           selfref_o,
    output logic [PSW-1:0] pstate_o,
    output logic           rfsh_lvl_o,
    output logic           phy_init_start_o,
    output logic [PSW-1:0] phy_freq_o,
    output logic           clk_sw_req_o,
    output logic           sw_done_o
);
    fsc_state_e     st_q, st_d;
    logic [PSW-1:0] tgt_q;
    logic [PSW-1:0] pstate_q;
    logic           rfsh_q;
    logic           in_sr;

    assign in_sr = (op_mode_i == OPMODE_SR_SW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start_i) st_d = ST_SWD_CLR;
            ST_SWD_CLR:  st_d = ST_QUIESCE;
            ST_QUIESCE:  if (!port_busy_rd_i && !port_busy_wr_i) st_d = ST_DRAIN;
            ST_DRAIN:    if (wrq_empty_i && rdq_empty_i) st_d = ST_SR_ENTER;
            ST_SR_ENTER: if (in_sr) st_d = ST_RFSH_UPD;
            ST_RFSH_UPD: st_d = ST_PHY_LOW;
            ST_PHY_LOW:  st_d = ST_PHY_HIGH;
            ST_PHY_HIGH: if (!phy_init_cmpl_i) st_d = ST_CLK_SW;
            ST_CLK_SW:   if (clk_sw_ack_i) st_d = ST_PHY_DROP;
            ST_PHY_DROP: if (phy_init_cmpl_i) st_d = ST_GUARD;
            ST_GUARD:    if (guard_done_i) st_d = ST_SR_EXIT;
            ST_SR_EXIT:  if (!in_sr) st_d = ST_MR_PROG;
            ST_MR_PROG:  if (mr_done_i) st_d = ST_RESTORE;
            ST_RESTORE:  st_d = ST_SW_DONE;
            ST_SW_DONE:  if (sw_done_ack_i) st_d = ST_FINISH;
            ST_FINISH:   st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // data registers: latched target, published state, refresh level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            pstate_q <= '0;
            rfsh_q   <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start_i) begin
                tgt_q <= target_i;
            end
            if (st_q == ST_RFSH_UPD) begin
                pstate_q <= tgt_q;
                rfsh_q   <= ~rfsh_q;
            end
        end
    end

    // output decode
    always_comb begin
        busy_o           = (st_q != ST_IDLE);
        done_o           = (st_q == ST_FINISH);
        sw_done_o        = (st_q == ST_IDLE) || (st_q == ST_SW_DONE) || (st_q == ST_FINISH);
        port_en_o        = (st_q == ST_IDLE) || (st_q == ST_SWD_CLR) || (st_q == ST_RESTORE)
                        || (st_q == ST_SW_DONE) || (st_q == ST_FINISH);
        hif_dis_o        = (st_q inside {ST_DRAIN, ST_SR_ENTER, ST_RFSH_UPD, ST_PHY_LOW,
                                         ST_PHY_HIGH, ST_CLK_SW, ST_PHY_DROP, ST_GUARD,
                                         ST_SR_EXIT, ST_MR_PROG});
        selfref_o        = (st_q inside {ST_SR_ENTER, ST_RFSH_UPD, ST_PHY_LOW, ST_PHY_HIGH,
                                         ST_CLK_SW, ST_PHY_DROP, ST_GUARD});
        phy_init_start_o = (st_q == ST_PHY_HIGH) || (st_q == ST_CLK_SW);
        clk_sw_req_o     = (st_q == ST_CLK_SW);
        guard_run_o      = (st_q == ST_GUARD);
        mr_go_o          = (st_q == ST_MR_PROG);
        pstate_o         = pstate_q;
        phy_freq_o       = pstate_q;
        rfsh_lvl_o       = rfsh_q;
    end

    // R2: host disable only after both ports report idle
    p_hif_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hif_dis_o) |-> $past(!port_busy_rd_i && !port_busy_wr_i));

    // R3: self-refresh request only after both queues are empty
    p_sr_after_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selfref_o) |-> $past(wrq_empty_i && rdq_empty_i));

    // R4: published state changes only once self-refresh was confirmed
    p_pstate_in_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(rfsh_lvl_o) |-> $past(selfref_o));

    // R5: clock switch only after init-complete went low
    p_clksw_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sw_req_o) |-> $past(!phy_init_cmpl_i));

    // R5: clock-switch request held until acknowledged
    p_clksw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sw_req_o && !clk_sw_ack_i |=> clk_sw_req_o);

    // R11: start while busy never alters the latched target
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(tgt_q) || !$past(busy_o));

endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq import fsc_pkg::*; #(
    parameter int unsigned NUM_PSTATES = 4,
    parameter int unsigned NUM_RANKS   = 2,
    parameter int unsigned CLK_MHZ     = 250,
    parameter int unsigned GUARD_US    = 14,
    localparam int unsigned PSW = (NUM_PSTATES > 1) ? $clog2(NUM_PSTATES) : 1,
    localparam int unsigned RW  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [PSW-1:0] target_i,
    output logic           busy_o,
    output logic           done_o,
    input  logic           port_busy_rd_i,
    input  logic           port_busy_wr_i,
    input  logic           wrq_empty_i,
    input  logic           rdq_empty_i,
    input  logic [5:0]     op_mode_i,
    input  logic           phy_init_cmpl_i,
    input  logic           clk_sw_ack_i,
    input  logic           sw_done_ack_i,
    input  logic           mr_ack_i,
    output logic           port_en_o,
    output logic           hif_dis_o,
    output logic           selfref_o,
    output logic [PSW-1:0] pstate_o,
    output logic           rfsh_lvl_o,
    output logic           phy_init_start_o,
    output logic [PSW-1:0] phy_freq_o,
    output logic           clk_sw_req_o,
    output logic           sw_done_o,
    output logic           mr_req_o,
    output logic [2:0]     mr_addr_o,
    output logic [2:0]     mr_sel_o,
    output logic [RW-1:0]  mr_rank_o
);
    localparam int unsigned GUARD_CYC = CLK_MHZ * GUARD_US;

    logic guard_run, guard_done, mr_go, mr_done;

    fsc_ctrl #(.PSW(PSW)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .target_i         (target_i),
        .port_busy_rd_i   (port_busy_rd_i),
        .port_busy_wr_i   (port_busy_wr_i),
        .wrq_empty_i      (wrq_empty_i),
        .rdq_empty_i      (rdq_empty_i),
        .op_mode_i        (op_mode_i),
        .phy_init_cmpl_i  (phy_init_cmpl_i),
        .clk_sw_ack_i     (clk_sw_ack_i),
        .sw_done_ack_i    (sw_done_ack_i),
        .guard_done_i     (guard_done),
        .mr_done_i        (mr_done),
        .guard_run_o      (guard_run),
        .mr_go_o          (mr_go),
        .busy_o           (busy_o),
        .done_o           (done_o),
        .port_en_o        (port_en_o),
        .hif_dis_o        (hif_dis_o),
        .selfref_o        (selfref_o),
        .pstate_o         (pstate_o),
        .rfsh_lvl_o       (rfsh_lvl_o),
        .phy_init_start_o (phy_init_start_o),
        .phy_freq_o       (phy_freq_o),
        .clk_sw_req_o     (clk_sw_req_o),
        .sw_done_o        (sw_done_o)
    );

    fsc_guard_timer #(.CYCLES(GUARD_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (guard_run),
        .expired_o (guard_done)
    );

    fsc_mr_issuer #(.NUM_RANKS(NUM_RANKS)) u_mr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mr_go),
        .ack_i  (mr_ack_i),
        .req_o  (mr_req_o),
        .addr_o (mr_addr_o),
        .sel_o  (mr_sel_o),
        .rank_o (mr_rank_o),
        .done_o (mr_done)
    );

    // R8: no mode-register traffic while self-refresh is requested
    p_mr_outside_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req_o |-> !selfref_o && !hif_dis_o == 1'b0);

    // R10: completion only with traffic fully restored
    p_done_restored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sw_done_o && port_en_o && !hif_dis_o && busy_o);

    // R6: init start never high while self-refresh is not requested
    p_init_in_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_init_start_o |-> selfref_o);

endmodule

// File: tb/tb_freq_change_seq.sv
`timescale 1ns/1ps
module tb_freq_change_seq;
    localparam int unsigned NRANK = 2;
    localparam int unsigned GUARD = 250 * 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] target_i = '0;
    logic       port_busy_rd_i = 1'b1, port_busy_wr_i = 1'b1;
    logic       wrq_empty_i = 1'b0, rdq_empty_i = 1'b0;
    logic [5:0] op_mode_i = 6'h00;
    logic       phy_init_cmpl_i = 1'b1;
    logic       clk_sw_ack_i = 1'b0, sw_done_ack_i = 1'b0, mr_ack_i = 1'b0;
    logic       busy_o, done_o, port_en_o, hif_dis_o, selfref_o, rfsh_lvl_o;
    logic       phy_init_start_o, clk_sw_req_o, sw_done_o, mr_req_o;
    logic [1:0] pstate_o, phy_freq_o;
    logic [2:0] mr_addr_o, mr_sel_o;
    logic       mr_rank_o;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    freq_change_seq #(.NUM_PSTATES(4), .NUM_RANKS(NRANK), .CLK_MHZ(250), .GUARD_US(14)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .busy_o(busy_o), .done_o(done_o),
        .port_busy_rd_i(port_busy_rd_i), .port_busy_wr_i(port_busy_wr_i),
        .wrq_empty_i(wrq_empty_i), .rdq_empty_i(rdq_empty_i), .op_mode_i(op_mode_i),
        .phy_init_cmpl_i(phy_init_cmpl_i), .clk_sw_ack_i(clk_sw_ack_i),
        .sw_done_ack_i(sw_done_ack_i), .mr_ack_i(mr_ack_i),
        .port_en_o(port_en_o), .hif_dis_o(hif_dis_o), .selfref_o(selfref_o),
        .pstate_o(pstate_o), .rfsh_lvl_o(rfsh_lvl_o), .phy_init_start_o(phy_init_start_o),
        .phy_freq_o(phy_freq_o), .clk_sw_req_o(clk_sw_req_o), .sw_done_o(sw_done_o),
        .mr_req_o(mr_req_o), .mr_addr_o(mr_addr_o), .mr_sel_o(mr_sel_o), .mr_rank_o(mr_rank_o)
    );

    function automatic int exp_slot(input int addr);
        return (addr == 6) ? 7 : addr;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_seq(input logic [1:0] tgt, input bit restart_mid);
        logic [1:0] old_ps;
        logic       old_lvl;
        int         n;
        old_ps  = pstate_o;
        old_lvl = rfsh_lvl_o;
        port_busy_rd_i = 1'b1; port_busy_wr_i = 1'b1;
        wrq_empty_i = 1'b0; rdq_empty_i = 1'b0;
        start_i = 1'b1; target_i = tgt;
        @(negedge clk);
        start_i = 1'b0; target_i = ~tgt;
        chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
        chk(sw_done_o == 1'b0 && port_en_o == 1'b1, "R2", "sw_done low, port open",
            {sw_done_o, port_en_o}, 1);
        @(negedge clk);
        chk(port_en_o == 1'b0, "R2", "port closed", port_en_o, 0);
        // one busy flag clears first
        idle_cycles($urandom_range(3, 1));
        port_busy_rd_i = 1'b0;
        if (restart_mid) begin
            start_i = 1'b1; target_i = tgt + 2'd1;
        end
        idle_cycles($urandom_range(3, 1));
        start_i = 1'b0;
        chk(hif_dis_o == 1'b0, "R2", "host disable waits for write port", hif_dis_o, 0);
        port_busy_wr_i = 1'b0;
        @(negedge clk);
        chk(hif_dis_o == 1'b1, "R2", "host disabled", hif_dis_o, 1);
        // drain: only one queue empty at first
        wrq_empty_i = 1'b1;
        idle_cycles($urandom_range(3, 1));
        chk(selfref_o == 1'b0, "R3", "self-refresh waits for read queue", selfref_o, 0);
        rdq_empty_i = 1'b1;
        @(negedge clk);
        chk(selfref_o == 1'b1, "R3", "self-refresh requested", selfref_o, 1);
        // partial operating mode code
        op_mode_i = 6'h03;
        idle_cycles($urandom_range(4, 2));
        chk(pstate_o == old_ps && rfsh_lvl_o == old_lvl, "R4", "no update on mode 0x03",
            rfsh_lvl_o, old_lvl);
        chk(phy_init_start_o == 1'b0, "R3", "waits for exact 0x23", phy_init_start_o, 0);
        op_mode_i = 6'h23;
        idle_cycles(2);
        chk(pstate_o == tgt && phy_freq_o == tgt, "R4", "state index published", pstate_o, tgt);
        chk(rfsh_lvl_o == ~old_lvl, "R4", "refresh level inverted", rfsh_lvl_o, !old_lvl);
        chk(phy_init_start_o == 1'b0, "R5", "init start low phase", phy_init_start_o, 0);
        @(negedge clk);
        chk(phy_init_start_o == 1'b1, "R5", "init start high", phy_init_start_o, 1);
        idle_cycles($urandom_range(4, 1));
        chk(clk_sw_req_o == 1'b0, "R5", "clock switch waits for init low", clk_sw_req_o, 0);
        phy_init_cmpl_i = 1'b0;
        @(negedge clk);
        chk(clk_sw_req_o == 1'b1, "R5", "clock switch requested", clk_sw_req_o, 1);
        idle_cycles($urandom_range(4, 1));
        chk(clk_sw_req_o == 1'b1, "R5", "clock switch held", clk_sw_req_o, 1);
        clk_sw_ack_i = 1'b1;
        @(negedge clk);
        clk_sw_ack_i = 1'b0;
        chk(clk_sw_req_o == 1'b0 && phy_init_start_o == 1'b0, "R6", "init start dropped",
            {clk_sw_req_o, phy_init_start_o}, 0);
        idle_cycles($urandom_range(5, 2));
        chk(selfref_o == 1'b1, "R6", "self-refresh held until init complete", selfref_o, 1);
        phy_init_cmpl_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (selfref_o && n < GUARD + 20);
        chk(n == GUARD + 1, "R7", "guard cycles before release", n, GUARD + 1);
        idle_cycles($urandom_range(4, 1));
        chk(mr_req_o == 1'b0, "R8", "no MR write while mode reads 0x23", mr_req_o, 0);
        op_mode_i = 6'h00;
        @(negedge clk);
        for (int r = 0; r < NRANK; r++) begin
            for (int a = 0; a < 7; a++) begin
                chk(mr_req_o == 1'b1 && mr_addr_o == a, "R9", "MR address", mr_addr_o, a);
                chk(mr_sel_o == exp_slot(a), "R9", "MR slot", mr_sel_o, exp_slot(a));
                chk(mr_rank_o == r, "R9", "MR rank", mr_rank_o, r);
                idle_cycles($urandom_range(2, 0));
                chk(mr_req_o && mr_addr_o == a, "R9", "MR request held", mr_addr_o, a);
                mr_ack_i = 1'b1;
                @(negedge clk);
                mr_ack_i = 1'b0;
            end
        end
        chk(mr_req_o == 1'b0, "R9", "no extra MR write", mr_req_o, 0);
        @(negedge clk);
        chk(port_en_o && !hif_dis_o && !sw_done_o, "R10", "traffic restored before sw_done",
            {port_en_o, hif_dis_o, sw_done_o}, 3'b100);
        @(negedge clk);
        chk(sw_done_o == 1'b1, "R10", "sw_done set", sw_done_o, 1);
        idle_cycles($urandom_range(3, 1));
        chk(done_o == 1'b0 && busy_o == 1'b1, "R10", "waiting for sw_done ack", done_o, 0);
        sw_done_ack_i = 1'b1;
        @(negedge clk);
        sw_done_ack_i = 1'b0;
        chk(done_o == 1'b1 && busy_o == 1'b1, "R10", "done pulse", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R11", "idle, no second run", busy_o, 0);
        chk(pstate_o == tgt, "R11", "first target kept", pstate_o, tgt);
        idle_cycles(2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && sw_done_o && port_en_o && !hif_dis_o && !selfref_o,
            "R1", "reset control outputs", {busy_o, sw_done_o, port_en_o}, 3'b011);
        chk(!phy_init_start_o && !clk_sw_req_o && !mr_req_o, "R1", "reset requests",
            {phy_init_start_o, clk_sw_req_o, mr_req_o}, 0);
        chk(pstate_o == 2'd0 && rfsh_lvl_o == 1'b0, "R1", "reset state index", pstate_o, 0);
        run_seq(2'd2, 1'b0);
        run_seq(2'd1, 1'b1);
        run_seq(2'd1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            run_seq(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)));
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule